// File: doc/BRIEF.md
# Call Stack Frame Unit

This unit supports subroutine linkage in a pipelined processor. When a call reaches the ALU stage, it saves four things on a small stack: the caller's OPEN and ACTIVE frame pointers, the address after the call, and the return destination code. The unit then loads the callee's frame pointers. A return in its IR stage reads the saved address from a registered top-of-stack copy, which feeds the next-PC multiplexer directly. When the return completes, the saved frame pointers are restored.

The stack storage has a write port and an unregistered read. After a pop, the next entry is read back on the following tick. This one-tick refill is why two returns on consecutive ticks are not allowed. The unit detects that case, ignores the second return and flags it.

Software can load all three frame registers (OPEN, ACTIVE, RETURN) over the functional bus. That write is double staged: holding registers first, then the real registers one tick later. A hold-off counter reports when the frames may be read again and when call or return operations may resume. Calls and returns issued during the hold-off window are ignored and flagged.

Top module: `frame_stack_unit`

## Requirements
- R1: While `rst` is high and on the first tick after it, the stack is empty, `ret_valid_o`, `ret_pc_o`, `ret_dst_o` and all frame outputs are zero, and every flag and busy output is low.
- R2: A call (`call_en`) accepted in tick c pushes {current OPEN, current ACTIVE, `call_pc`+1 modulo 2^PC_W, `call_dst`}. From tick c+1, `ret_pc_o`/`ret_dst_o` show that entry with `ret_valid_o` high, OPEN/ACTIVE hold `call_open`/`call_act`, and RETURN is unchanged.
- R3: A return (`ret_en`) in tick r, with `ret_valid_o` high, consumes the shown entry. In tick r+1, OPEN/ACTIVE hold the saved pointers and `ret_valid_o` and `ret_pc_o` are zero. From tick r+2, the next older entry is shown, if one exists.
- R4: A return in tick r+1 directly after an accepted return is ignored. `hazard_o` is high in tick r+2, and the stack depth and contents are unchanged.
- R5: The stack holds DEPTH (16) entries. A call on a full stack leaves the stack and the shown entry unchanged and raises `ovf_o` for the next tick.
- R6: A return on an empty stack changes nothing and raises `unf_o` for the next tick.
- R7: A bus write (`fbus_we`) in tick w carries OPEN in `fbus_wdata[23:16]`, ACTIVE in [15:8] and RETURN in [7:0]. The frame outputs keep their old values in tick w+1 and show the written values from tick w+2.
- R8: After a bus write in tick w, `frame_busy_o` is high in ticks w+1 to w+4, and `ctl_busy_o` is high in ticks w+1 to w+5.
- R9: A call or return requested while `ctl_busy_o` is high is ignored and raises `hazard_o` for the next tick.
- R10: A call and a return accepted in the same tick replace the top entry with the call's entry and leave the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_en | input | 1 | Call in ALU stage this tick |
| call_pc | input | 16 | Address of the call instruction |
| call_dst | input | 4 | Return destination code to save |
| call_open | input | 8 | Callee OPEN pointer |
| call_act | input | 8 | Callee ACTIVE pointer |
| ret_en | input | 1 | Return in IR stage this tick |
| fbus_we | input | 1 | Functional-bus write to the frame registers |
| fbus_wdata | input | 24 | Frame write data {OPEN, ACTIVE, RETURN} |
| open_o | output | 8 | Current OPEN pointer |
| active_o | output | 8 | Current ACTIVE pointer |
| return_o | output | 8 | Current RETURN pointer |
| ret_pc_o | output | 16 | Return address for the next-PC mux |
| ret_dst_o | output | 4 | Saved return destination |
| ret_valid_o | output | 1 | Top entry is present and usable |
| hazard_o | output | 1 | Ignored back-to-back return or hold-off violation |
| ovf_o | output | 1 | Call refused on a full stack |
| unf_o | output | 1 | Return refused on an empty stack |
| frame_busy_o | output | 1 | Frames may not be read yet |
| ctl_busy_o | output | 1 | Calls and returns may not issue yet |

## Verification
The bench issues two returns on consecutive ticks with two entries stacked. If the refill latency were ignored, the second return would either pop the older entry unseen or hand out a zero address. The bench checks that the older entry still comes back afterwards. It fills the stack to its depth, then pushes once more and drains it. A pointer that wrapped would return the wrong addresses, because the 16 return addresses are all distinct. It steps through a bus write tick by tick and probes the hold-off edges with refused and accepted calls. A design that loaded the frames one tick early, or ended a busy window one tick off, would fail at that exact tick.

// File: rtl/cstk_pkg.sv
package cstk_pkg;
  localparam int unsigned PC_W  = 16;
  localparam int unsigned FP_W  = 8;
  localparam int unsigned DST_W = 4;

  typedef struct packed {
    logic [FP_W-1:0]  open_fp;
    logic [FP_W-1:0]  act_fp;
    logic [PC_W-1:0]  pc;
    logic [DST_W-1:0] dst;
  } cs_entry_t;

  typedef struct packed {
    logic [FP_W-1:0] open_fp;
    logic [FP_W-1:0] act_fp;
    logic [FP_W-1:0] rtn_fp;
  } frame_set_t;

  localparam int unsigned ENT_W = $bits(cs_entry_t);
  localparam int unsigned FRM_W = $bits(frame_set_t);
endpackage

// File: rtl/cstk_mem.sv
module cstk_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 36,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  // Synchronous write, asynchronous read: maps onto distributed RAM.
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cstk_frames.sv
module cstk_frames
  import cstk_pkg::*;
#(
  parameter int unsigned CTL_HOLD   = 5,
  parameter int unsigned FRAME_HOLD = 4,
  localparam int unsigned CW        = $clog2(CTL_HOLD + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [FRM_W-1:0] wr_data,
  input  logic             call_ld,
  input  logic [FP_W-1:0]  call_open,
  input  logic [FP_W-1:0]  call_act,
  input  logic             ret_ld,
  input  logic [FP_W-1:0]  ret_open,
  input  logic [FP_W-1:0]  ret_act,
  output frame_set_t       frames_o,
  output logic             frame_busy_o,
  output logic             ctl_busy_o
);
  frame_set_t    frames_q, stg_q;
  logic          stg_v_q;
  logic [CW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frames_q <= '0;
      stg_q    <= '0;
      stg_v_q  <= 1'b0;
      hold_q   <= '0;
    end else begin
      stg_v_q <= wr_en;
      if (wr_en) stg_q <= frame_set_t'(wr_data);
      if (wr_en)             hold_q <= CW'(CTL_HOLD);
      else if (hold_q != '0) hold_q <= hold_q - CW'(1);
      // staged copy lands one tick after the bus write
      if (stg_v_q) frames_q <= stg_q;
      else if (call_ld) begin
        frames_q.open_fp <= call_open;
        frames_q.act_fp  <= call_act;
      end else if (ret_ld) begin
        frames_q.open_fp <= ret_open;
        frames_q.act_fp  <= ret_act;
      end
    end
  end

  assign frames_o     = frames_q;
  assign ctl_busy_o   = (hold_q != '0);
  assign frame_busy_o = (hold_q > CW'(CTL_HOLD - FRAME_HOLD));

  a_r8_busy_after_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (ctl_busy_o && frame_busy_o));
  a_r7_staged_copy: assert property (@(posedge clk) disable iff (rst)
    stg_v_q |=> (frames_q == $past(stg_q)));
  a_r8_frame_within_ctl: assert property (@(posedge clk) disable iff (rst)
    frame_busy_o |-> ctl_busy_o);
endmodule

// File: rtl/frame_stack_unit.sv
module frame_stack_unit
  import cstk_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned SPW  = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  call_en,
  input  logic [PC_W-1:0]       call_pc,
  input  logic [DST_W-1:0]      call_dst,
  input  logic [FP_W-1:0]       call_open,
  input  logic [FP_W-1:0]       call_act,
  input  logic                  ret_en,
  input  logic                  fbus_we,
  input  logic [3*FP_W-1:0]     fbus_wdata,
  output logic [FP_W-1:0]       open_o,
  output logic [FP_W-1:0]       active_o,
  output logic [FP_W-1:0]       return_o,
  output logic [PC_W-1:0]       ret_pc_o,
  output logic [DST_W-1:0]      ret_dst_o,
  output logic                  ret_valid_o,
  output logic                  hazard_o,
  output logic                  ovf_o,
  output logic                  unf_o,
  output logic                  frame_busy_o,
  output logic                  ctl_busy_o
);
  logic [SPW-1:0] sp_q, sp_m1;
  cs_entry_t      top_q, new_ent;
  logic           valid_q, hazard_q, ovf_q, unf_q;
  frame_set_t     frames;
  logic           busy, frame_busy;
  logic           ret_req, call_req, pop_ok, push_ok, ret_early, ret_empty, call_full, refill, full;
  logic [AW-1:0]  waddr;
  logic [ENT_W-1:0] rd_word;

  assign sp_m1     = sp_q - SPW'(1);
  assign full      = (sp_q == SPW'(DEPTH));
  assign ret_req   = ret_en && !busy;
  assign call_req  = call_en && !busy;
  assign pop_ok    = ret_req && valid_q;
  assign ret_empty = ret_req && (sp_q == '0);
  assign ret_early = ret_req && !valid_q && (sp_q != '0);
  assign push_ok   = call_req && (!full || pop_ok);
  assign call_full = call_req && full && !pop_ok;
  assign refill    = !valid_q && (sp_q != '0) && !push_ok;
  assign waddr     = pop_ok ? AW'(sp_m1) : AW'(sp_q);

  always_comb begin
    new_ent.open_fp = frames.open_fp;
    new_ent.act_fp  = frames.act_fp;
    new_ent.pc      = call_pc + PC_W'(1);
    new_ent.dst     = call_dst;
  end

  cstk_mem #(.DEPTH(DEPTH), .W(ENT_W)) i_mem (
    .clk   (clk),
    .we    (push_ok),
    .waddr (waddr),
    .wdata (new_ent),
    .raddr (AW'(sp_m1)),
    .rdata (rd_word)
  );

  cstk_frames i_frames (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (fbus_we),
    .wr_data      (fbus_wdata),
    .call_ld      (push_ok),
    .call_open    (call_open),
    .call_act     (call_act),
    .ret_ld       (pop_ok),
    .ret_open     (top_q.open_fp),
    .ret_act      (top_q.act_fp),
    .frames_o     (frames),
    .frame_busy_o (frame_busy),
    .ctl_busy_o   (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q     <= '0;
      top_q    <= '0;
      valid_q  <= 1'b0;
      hazard_q <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
    end else begin
      hazard_q <= ((ret_en || call_en) && busy) || ret_early;
      ovf_q    <= call_full;
      unf_q    <= ret_empty;
      if (push_ok && !pop_ok)      sp_q <= sp_q + SPW'(1);
      else if (pop_ok && !push_ok) sp_q <= sp_m1;
      if (push_ok) begin
        top_q   <= new_ent;
        valid_q <= 1'b1;
      end else if (pop_ok) begin
        top_q   <= '0;
        valid_q <= 1'b0;
      end else if (refill) begin
        top_q   <= cs_entry_t'(rd_word);
        valid_q <= 1'b1;
      end
    end
  end

  assign open_o       = frames.open_fp;
  assign active_o     = frames.act_fp;
  assign return_o     = frames.rtn_fp;
  assign ret_pc_o     = top_q.pc;
  assign ret_dst_o    = top_q.dst;
  assign ret_valid_o  = valid_q;
  assign hazard_o     = hazard_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
  assign frame_busy_o = frame_busy;
  assign ctl_busy_o   = busy;

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    sp_q <= SPW'(DEPTH));
  a_r5_full_refused: assert property (@(posedge clk) disable iff (rst)
    (call_en && !busy && full && !ret_en) |=> (ovf_o && $stable(sp_q)));
  a_r6_empty_refused: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !busy && sp_q == '0 && !call_en) |=> (unf_o && sp_q == '0));
  a_r4_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !busy && !valid_q && sp_q != '0 && !call_en) |=> (hazard_o && $stable(sp_q)));
  a_r3_pop_clears_valid: assert property (@(posedge clk) disable iff (rst)
    (ret_en && !busy && valid_q && !call_en) |=> (!ret_valid_o && ret_pc_o == '0));
  a_r2_push_shows_entry: assert property (@(posedge clk) disable iff (rst)
    (call_en && !busy && !full) |=> ret_valid_o);
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    ((call_en || ret_en) && busy) |=> (hazard_o && $stable(sp_q)));
endmodule

// File: tb/test_frame_stack_unit.sv
module test_frame_stack_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_en = 1'b0, ret_en = 1'b0, fbus_we = 1'b0;
  logic [15:0] call_pc = '0;
  logic [3:0]  call_dst = '0;
  logic [7:0]  call_open = '0, call_act = '0;
  logic [23:0] fbus_wdata = '0;
  logic [7:0]  open_o, active_o, return_o;
  logic [15:0] ret_pc_o;
  logic [3:0]  ret_dst_o;
  logic        ret_valid_o, hazard_o, ovf_o, unf_o, frame_busy_o, ctl_busy_o;
  int          checks = 0, errs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_stack_unit i_frame_stack_unit (
    .clk(clk), .rst(rst), .call_en(call_en), .call_pc(call_pc), .call_dst(call_dst),
    .call_open(call_open), .call_act(call_act), .ret_en(ret_en), .fbus_we(fbus_we),
    .fbus_wdata(fbus_wdata), .open_o(open_o), .active_o(active_o), .return_o(return_o),
    .ret_pc_o(ret_pc_o), .ret_dst_o(ret_dst_o), .ret_valid_o(ret_valid_o),
    .hazard_o(hazard_o), .ovf_o(ovf_o), .unf_o(unf_o), .frame_busy_o(frame_busy_o),
    .ctl_busy_o(ctl_busy_o));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_call(logic [15:0] pc, logic [3:0] dst, logic [7:0] op, logic [7:0] ac);
    call_en = 1'b1; call_pc = pc; call_dst = dst; call_open = op; call_act = ac;
    tick();
    call_en = 1'b0;
  endtask

  task automatic do_ret();
    ret_en = 1'b1; tick(); ret_en = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; repeat (3) tick(); rst = 1'b0; tick();
    chk("R1", "valid", ret_valid_o, 0);
    chk("R1", "pc", ret_pc_o, 0);
    chk("R1", "frames", {open_o, active_o, return_o}, 0);
    chk("R1", "flags", {hazard_o, ovf_o, unf_o, frame_busy_o, ctl_busy_o}, 0);
  endtask

  task automatic t_call_ret();
    do_call(16'h1234, 4'd3, 8'h20, 8'h10);
    chk("R2", "pc1", ret_pc_o, 16'h1235);
    chk("R2", "dst1", ret_dst_o, 3);
    chk("R2", "valid1", ret_valid_o, 1);
    chk("R2", "frames1", {open_o, active_o, return_o}, 24'h201000);
    do_call(16'h2000, 4'd5, 8'h30, 8'h20);
    chk("R2", "pc2", ret_pc_o, 16'h2001);
    chk("R2", "dst2", ret_dst_o, 5);
    do_ret();
    chk("R3", "restored", {open_o, active_o}, 16'h2010);
    chk("R3", "gap valid", ret_valid_o, 0);
    chk("R3", "gap pc", ret_pc_o, 0);
    tick();
    chk("R3", "refill pc", ret_pc_o, 16'h1235);
    chk("R3", "refill dst", ret_dst_o, 3);
    chk("R3", "refill valid", ret_valid_o, 1);
    do_ret();
    chk("R3", "restored0", {open_o, active_o}, 0);
    tick();
    chk("R3", "empty valid", ret_valid_o, 0);
  endtask

  task automatic t_underflow();
    do_ret();
    chk("R6", "unf", unf_o, 1);
    chk("R6", "valid", ret_valid_o, 0);
    chk("R6", "frames", {open_o, active_o}, 0);
    tick();
    chk("R6", "unf pulse", unf_o, 0);
  endtask

  task automatic t_back_to_back();
    do_call(16'h0100, 4'd1, 8'h01, 8'h02);
    do_call(16'h0200, 4'd2, 8'h03, 8'h04);
    ret_en = 1'b1; tick();
    chk("R4", "no pc in gap", {ret_valid_o, ret_pc_o}, 0);
    tick(); ret_en = 1'b0;
    chk("R4", "hazard", hazard_o, 1);
    chk("R4", "older kept", ret_pc_o, 16'h0101);
    chk("R4", "valid", ret_valid_o, 1);
    do_ret(); tick();
    chk("R4", "empty after one pop", ret_valid_o, 0);
  endtask

  task automatic t_replace();
    do_call(16'h0300, 4'd6, 8'h00, 8'h00);
    call_en = 1'b1; ret_en = 1'b1; call_pc = 16'h0400; call_dst = 4'd7;
    tick(); call_en = 1'b0; ret_en = 1'b0;
    chk("R10", "replaced pc", ret_pc_o, 16'h0401);
    chk("R10", "valid", ret_valid_o, 1);
    do_ret(); tick();
    chk("R10", "depth one", ret_valid_o, 0);
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 16; k++) do_call(16'(k * 16), 4'(k), 8'h00, 8'h00);
    chk("R5", "top", ret_pc_o, 16'h00F1);
    do_call(16'hFFF0, 4'd9, 8'h00, 8'h00);
    chk("R5", "ovf", ovf_o, 1);
    chk("R5", "top kept", ret_pc_o, 16'h00F1);
    tick();
    chk("R5", "ovf pulse", ovf_o, 0);
    for (int k = 15; k >= 0; k--) begin
      chk("R5", "drain pc", ret_pc_o, 32'(16'(k * 16 + 1)));
      do_ret(); tick();
    end
    chk("R5", "drained", ret_valid_o, 0);
    do_call(16'hFFFF, 4'd0, 8'h00, 8'h00);
    chk("R2", "pc wrap", {ret_valid_o, ret_pc_o}, 32'h10000);
    do_ret(); tick();
  endtask

  task automatic t_staged();
    fbus_we = 1'b1; fbus_wdata = 24'h445566; tick(); fbus_we = 1'b0;
    chk("R7", "old in w+1", {open_o, active_o, return_o}, 0);
    chk("R8", "busy w+1", {frame_busy_o, ctl_busy_o}, 2'b11);
    call_en = 1'b1; call_pc = 16'h0500; tick(); call_en = 1'b0;
    chk("R7", "new in w+2", {open_o, active_o, return_o}, 24'h445566);
    chk("R9", "call refused", {hazard_o, ret_valid_o}, 2'b10);
    tick(); tick();
    chk("R8", "busy w+4", {frame_busy_o, ctl_busy_o}, 2'b11);
    tick();
    chk("R8", "w+5", {frame_busy_o, ctl_busy_o}, 2'b01);
    ret_en = 1'b1; tick(); ret_en = 1'b0;
    chk("R9", "ret refused", {hazard_o, unf_o}, 2'b10);
    chk("R8", "w+6", {frame_busy_o, ctl_busy_o}, 2'b00);
    do_call(16'h0600, 4'd4, 8'h11, 8'h22);
    chk("R9", "call after hold", {ret_valid_o, ret_pc_o}, 32'h10601);
    chk("R2", "return kept", {open_o, active_o, return_o}, 24'h112266);
    do_ret(); tick();
  endtask

  initial begin
    t_reset();
    t_call_ret();
    t_underflow();
    t_back_to_back();
    t_replace();
    t_overflow();
    t_staged();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule